// File: doc/BRIEF.md
# Write-Completion Acknowledge Poller

This block is a two-wire bus master whose only job is to wait until a serial EEPROM has finished programming. The EEPROM does not answer its address while it programs. When the host pulses `startReq`, the poller takes in the 7-bit `slaveAddr` and sends probe transactions. Each probe is a start condition, the address with the direction bit set to write, one acknowledge clock and a stop condition. An acknowledged address means the memory is ready: the poller pulses `pollDone`. A missing acknowledge means the memory is still busy: the poller waits a configurable gap and probes again.

The number of probes is bounded. If `MAX_PROBES` probes all go unanswered, the poller pulses `pollTimeout` instead of `pollDone`. The bus pins are open-drain. The block only drives enables that pull SCL or SDA low, and it reads the resolved SDA level back on `sdaIn`. Bus timing comes from `QTR_CYCLES`, the length in clocks of one quarter of a bit period. Polling may begin in the first cycle after the write's stop condition.

Top module: `wrDonePoller`

## Requirements
- R1: Out of reset, and whenever the block is idle, `sclOe` and `sdaOe` are 0 (both lines released) and `pollDone` and `pollTimeout` are 0.
- R2: A `startReq` pulse while idle starts a probe. The probe begins with a start condition (SDA falls while SCL is high). Then eight bits follow, most significant first: the seven bits of `slaveAddr`, then a 0 as the write direction bit.
- R3: Outside the start and stop conditions, SDA changes only while SCL is low.
- R4: During each address bit and the acknowledge bit, SCL stays released (high) for exactly 2*QTR_CYCLES+1 clocks.
- R5: On the ninth clock the poller releases SDA and samples it while SCL is high. A low level is an acknowledge.
- R6: When the address is acknowledged, the poller sends a stop condition (SDA rises while SCL is high). It then raises `pollDone` for exactly one clock and goes back to idle.
- R7: When the address is not acknowledged, the poller sends a stop condition and waits at least GAP_CYCLES clocks (and at most GAP_CYCLES+2*QTR_CYCLES+4). Then it issues the next start condition.
- R8: When MAX_PROBES probes in a row go unacknowledged, `pollTimeout` rises for exactly one clock after the last stop. `pollDone` stays low and no further probe is made.
- R9: The address is captured when the run starts. While a run is in progress, `startReq` pulses and changes to `slaveAddr` have no effect on the probes sent or on the outcome.
- R10: Every probe ends with a stop condition, so a run issues as many stop conditions as start conditions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | One-clock pulse that begins a polling run |
| slaveAddr | input | 7 | Bus address of the memory to poll |
| sdaIn | input | 1 | Resolved level of the SDA line |
| sclOe | output | 1 | 1 pulls SCL low, 0 releases it |
| sdaOe | output | 1 | 1 pulls SDA low, 0 releases it |
| pollDone | output | 1 | One-clock pulse: the memory acknowledged |
| pollTimeout | output | 1 | One-clock pulse: the probe limit was reached without an acknowledge |

## Verification
The bench builds the poller with QTR_CYCLES=4, GAP_CYCLES=20 and MAX_PROBES=5. With these values a probe lasts about two hundred clocks, so a run of several probes, an exhausted probe limit and the gap between probes all fit in short directed scenarios. A behavioural open-drain memory model sits on the wires and withholds its acknowledge for a chosen number of probes. This makes it possible to check an immediate acknowledge, an acknowledge after several refusals, the timeout, a wrong address, and host activity in the middle of a run. The exact SCL high time and the bounds on the gap can be checked cycle by cycle at these small settings.

// File: rtl/pollPkg.sv
package pollPkg;

  typedef enum logic [1:0] {
    SYM_START = 2'd0,
    SYM_DATA  = 2'd1,
    SYM_ACK   = 2'd2,
    SYM_STOP  = 2'd3
  } symOp_e;

  typedef enum logic [2:0] {
    PS_IDLE  = 3'd0,
    PS_START = 3'd1,
    PS_ADDR  = 3'd2,
    PS_ACK   = 3'd3,
    PS_STOP  = 3'd4,
    PS_GAP   = 3'd5
  } pollState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic   go;           // launch one bus symbol
    symOp_e op;           // which symbol
    logic   captureAddr;  // latch the host address
    logic   reloadShift;  // refill the shift register from the latched address
  } pollStrobe_t;

endpackage

// File: rtl/pollDatapath.sv
module pollDatapath
  import pollPkg::*;
#(
  parameter int QTR_CYCLES = 125,
  parameter int ADDR_W     = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  pollStrobe_t       strb,
  input  logic [ADDR_W-1:0] slaveAddr,
  input  logic              sdaIn,
  output logic              sclOe,
  output logic              sdaOe,
  output logic              busy,
  output logic              symDone,
  output logic              ackSeen
);

  localparam int DIV_W  = (QTR_CYCLES > 1) ? $clog2(QTR_CYCLES) : 1;
  localparam int BYTE_W = ADDR_W + 1;

  logic [DIV_W-1:0]  divCnt;
  logic [1:0]        qIdx;
  symOp_e            curOp;
  logic [ADDR_W-1:0] addrHold;
  logic [BYTE_W-1:0] shiftReg;
  logic              qEnd;

  assign qEnd    = busy && (divCnt == DIV_W'(QTR_CYCLES - 1));
  assign symDone = qEnd && (qIdx == 2'd3);

  // A symbol is four quarters. Quarter 0 pulls SCL low (START leaves the
  // lines released). Quarter 1 moves SDA while SCL is low. Quarters 2 and 3
  // hold SCL high. START and STOP move SDA during the high half.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt   <= '0;
      qIdx     <= '0;
      curOp    <= SYM_START;
      addrHold <= '0;
      shiftReg <= '0;
      busy     <= 1'b0;
      sclOe    <= 1'b0;
      sdaOe    <= 1'b0;
      ackSeen  <= 1'b0;
    end else begin
      if (strb.captureAddr) addrHold <= slaveAddr;
      if (strb.go && !busy) begin
        busy   <= 1'b1;
        curOp  <= strb.op;
        qIdx   <= 2'd0;
        divCnt <= '0;
        if (strb.reloadShift) shiftReg <= {addrHold, 1'b0};
        if (strb.op == SYM_START) begin
          sclOe <= 1'b0;
          sdaOe <= 1'b0;
        end else begin
          sclOe <= 1'b1;
        end
      end else if (busy) begin
        if (qEnd) begin
          divCnt <= '0;
          qIdx   <= qIdx + 2'd1;
          case (qIdx)
            2'd0: begin
              case (curOp)
                SYM_START: sdaOe <= 1'b1;
                SYM_DATA:  sdaOe <= ~shiftReg[BYTE_W-1];
                SYM_ACK:   sdaOe <= 1'b0;
                SYM_STOP:  sdaOe <= 1'b1;
                default:   sdaOe <= sdaOe;
              endcase
            end
            2'd1: begin
              if (curOp != SYM_START) sclOe <= 1'b0;
            end
            2'd2: begin
              case (curOp)
                SYM_START: sclOe   <= 1'b1;
                SYM_STOP:  sdaOe   <= 1'b0;
                SYM_ACK:   ackSeen <= ~sdaIn;
                default:   ackSeen <= ackSeen;
              endcase
            end
            default: begin
              busy <= 1'b0;
              if (curOp == SYM_DATA) shiftReg <= shiftReg << 1;
            end
          endcase
        end else begin
          divCnt <= divCnt + DIV_W'(1);
        end
      end
    end
  end

  // R3: SDA is frozen while SCL is high during address and acknowledge bits
  a_r3_sda_steady_high: assert property (@(posedge clk) disable iff (!rstN)
    (busy && (curOp == SYM_DATA || curOp == SYM_ACK) && !sclOe && !$past(sclOe))
      |-> $stable(sdaOe));

  // R5: the line is released for the whole high half of the acknowledge bit
  a_r5_ack_released: assert property (@(posedge clk) disable iff (!rstN)
    (busy && curOp == SYM_ACK && qIdx >= 2'd2) |-> !sdaOe);

  // R2: control launches a symbol only when the datapath is free
  a_r2_go_when_free: assert property (@(posedge clk) disable iff (!rstN)
    strb.go |-> !busy);

endmodule

// File: rtl/pollControl.sv
module pollControl
  import pollPkg::*;
#(
  parameter int MAX_PROBES = 250,
  parameter int GAP_CYCLES = 2500,
  parameter int ADDR_W     = 7
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        startReq,
  input  logic        busy,
  input  logic        symDone,
  input  logic        ackSeen,
  output pollStrobe_t strb,
  output logic        pollDone,
  output logic        pollTimeout
);

  localparam int PROBE_W = $clog2(MAX_PROBES + 1);
  localparam int GAP_W   = (GAP_CYCLES > 1) ? $clog2(GAP_CYCLES) : 1;
  localparam int BIT_W   = $clog2(ADDR_W + 1);

  pollState_e         state;
  logic [BIT_W-1:0]   bitCnt;
  logic [PROBE_W-1:0] probeCnt;
  logic [GAP_W-1:0]   gapCnt;
  logic               symState;

  assign symState = (state == PS_START) || (state == PS_ADDR) ||
                    (state == PS_ACK)   || (state == PS_STOP);

  always_comb begin
    strb.go          = symState && !busy;
    strb.captureAddr = (state == PS_IDLE) && startReq;
    strb.reloadShift = (state == PS_START);
    case (state)
      PS_ADDR: strb.op = SYM_DATA;
      PS_ACK:  strb.op = SYM_ACK;
      PS_STOP: strb.op = SYM_STOP;
      default: strb.op = SYM_START;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state       <= PS_IDLE;
      bitCnt      <= '0;
      probeCnt    <= '0;
      gapCnt      <= '0;
      pollDone    <= 1'b0;
      pollTimeout <= 1'b0;
    end else begin
      pollDone    <= 1'b0;
      pollTimeout <= 1'b0;
      case (state)
        PS_IDLE: begin
          if (startReq) begin
            probeCnt <= '0;
            state    <= PS_START;
          end
        end
        PS_START: begin
          if (symDone) begin
            bitCnt <= '0;
            state  <= PS_ADDR;
          end
        end
        PS_ADDR: begin
          if (symDone) begin
            if (bitCnt == BIT_W'(ADDR_W)) state <= PS_ACK;
            else bitCnt <= bitCnt + BIT_W'(1);
          end
        end
        PS_ACK: begin
          if (symDone) begin
            probeCnt <= probeCnt + PROBE_W'(1);
            state    <= PS_STOP;
          end
        end
        PS_STOP: begin
          if (symDone) begin
            if (ackSeen) begin
              pollDone <= 1'b1;
              state    <= PS_IDLE;
            end else if (probeCnt == PROBE_W'(MAX_PROBES)) begin
              pollTimeout <= 1'b1;
              state       <= PS_IDLE;
            end else begin
              gapCnt <= '0;
              state  <= PS_GAP;
            end
          end
        end
        PS_GAP: begin
          if (gapCnt == GAP_W'(GAP_CYCLES - 1)) state <= PS_START;
          else gapCnt <= gapCnt + GAP_W'(1);
        end
        default: state <= PS_IDLE;
      endcase
    end
  end

  // R6: completion is a single-clock pulse
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    pollDone |=> !pollDone);

  // R8: timeout is a single-clock pulse and never coincides with completion
  a_r8_timeout_pulse: assert property (@(posedge clk) disable iff (!rstN)
    pollTimeout |=> !pollTimeout);
  a_r8_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(pollDone && pollTimeout));
  a_r8_probe_bound: assert property (@(posedge clk) disable iff (!rstN)
    probeCnt <= PROBE_W'(MAX_PROBES));

  // R7: a gap is entered only after an unacknowledged probe
  a_r7_gap_after_nack: assert property (@(posedge clk) disable iff (!rstN)
    (state == PS_GAP) |-> !ackSeen);

  // R1: no result pulses while the bus is in use by the next symbol
  a_r1_quiet_while_busy: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !(pollDone || pollTimeout));

endmodule

// File: rtl/wrDonePoller.sv
module wrDonePoller
  import pollPkg::*;
#(
  parameter int QTR_CYCLES = 125,
  parameter int GAP_CYCLES = 2500,
  parameter int MAX_PROBES = 250
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic [6:0] slaveAddr,
  input  logic       sdaIn,
  output logic       sclOe,
  output logic       sdaOe,
  output logic       pollDone,
  output logic       pollTimeout
);

  localparam int ADDR_W = 7;

  pollStrobe_t strb;
  logic        busy;
  logic        symDone;
  logic        ackSeen;

  pollControl #(
    .MAX_PROBES(MAX_PROBES),
    .GAP_CYCLES(GAP_CYCLES),
    .ADDR_W    (ADDR_W)
  ) ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startReq   (startReq),
    .busy       (busy),
    .symDone    (symDone),
    .ackSeen    (ackSeen),
    .strb       (strb),
    .pollDone   (pollDone),
    .pollTimeout(pollTimeout)
  );

  pollDatapath #(
    .QTR_CYCLES(QTR_CYCLES),
    .ADDR_W    (ADDR_W)
  ) dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .slaveAddr(slaveAddr),
    .sdaIn    (sdaIn),
    .sclOe    (sclOe),
    .sdaOe    (sdaOe),
    .busy     (busy),
    .symDone  (symDone),
    .ackSeen  (ackSeen)
  );

endmodule

// File: tb/wrDonePoller_test.sv
`timescale 1ns/1ps
module wrDonePoller_test;

  localparam int QTR = 4;
  localparam int GAP = 20;
  localparam int MAXP = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0;
  logic [6:0] slaveAddr = 7'h50;
  logic sclOe, sdaOe, pollDone, pollTimeout;
  logic slaveDrv = 1'b0;
  logic sclW, sdaW;

  int nChecks = 0;
  int nFails = 0;
  int cyc = 0;

  // memory model state
  logic [6:0] respondAddr = 7'h50;
  logic [6:0] expAddr = 7'h50;
  int nackFirst = 0;
  int probes = 0, starts = 0, stops = 0;
  int bitIdx = 0, badByte = 0, badHigh = 0;
  int tRise = 0, tStop = 0, minGap = 0, maxGap = 0;
  bit inFrame = 0, stopSeen = 0;
  logic [7:0] rxByte = '0;
  int doneCnt = 0, toCnt = 0;

  always #10 clk = ~clk;

  assign sclW = ~sclOe;
  assign sdaW = ~(sdaOe | slaveDrv);

  wrDonePoller #(.QTR_CYCLES(QTR), .GAP_CYCLES(GAP), .MAX_PROBES(MAXP)) uut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .slaveAddr(slaveAddr),
    .sdaIn(sdaW), .sclOe(sclOe), .sdaOe(sdaOe),
    .pollDone(pollDone), .pollTimeout(pollTimeout)
  );

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (rstN && pollDone) doneCnt <= doneCnt + 1;
    if (rstN && pollTimeout) toCnt <= toCnt + 1;
  end

  // start condition
  always @(negedge sdaW) begin
    if (rstN && sclW === 1'b1) begin
      starts++; probes++; inFrame = 1; bitIdx = 0;
      if (stopSeen) begin
        if (minGap == 0 || cyc - tStop < minGap) minGap = cyc - tStop;
        if (cyc - tStop > maxGap) maxGap = cyc - tStop;
      end
    end
  end
  // stop condition
  always @(posedge sdaW) begin
    if (rstN && sclW === 1'b1) begin
      stops++; inFrame = 0; tStop = cyc; stopSeen = 1;
    end
  end
  always @(posedge sclW) begin
    if (rstN && inFrame) begin
      tRise = cyc;
      if (bitIdx < 8) rxByte = {rxByte[6:0], sdaW};
      bitIdx++;
      if (bitIdx == 8 && rxByte != {expAddr, 1'b0}) badByte++;
    end
  end
  always @(negedge sclW) begin
    if (rstN && inFrame) begin
      if (bitIdx >= 1 && bitIdx <= 9 && (cyc - tRise) != 2 * QTR + 1) badHigh++;
      if (bitIdx == 8 && rxByte[7:1] == respondAddr && probes > nackFirst) slaveDrv = 1'b1;
      if (bitIdx == 9) slaveDrv = 1'b0;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clearStats();
    probes = 0; starts = 0; stops = 0; badByte = 0; badHigh = 0;
    minGap = 0; maxGap = 0; stopSeen = 0;
    @(negedge clk);
    doneCnt = 0; toCnt = 0;
  endtask

  task automatic pulseStart();
    @(negedge clk); startReq = 1'b1;
    @(negedge clk); startReq = 1'b0;
  endtask

  task automatic waitResult();
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (doneCnt != 0 || toCnt != 0) break;
    end
    repeat (3 * GAP + 300) @(negedge clk);
  endtask

  task automatic checkIdle(input string req);
    check(sclOe == 1'b0, req, sclOe, 0);
    check(sdaOe == 1'b0, req, sdaOe, 0);
  endtask

  task automatic testReset();
    check(sclOe == 0 && sdaOe == 0, "R1 reset lines", {sclOe, sdaOe}, 0);
    check(pollDone == 0 && pollTimeout == 0, "R1 reset flags", {pollDone, pollTimeout}, 0);
  endtask

  task automatic testImmediateAck();
    clearStats(); nackFirst = 0; respondAddr = 7'h50; expAddr = 7'h50; slaveAddr = 7'h50;
    pulseStart(); waitResult();
    check(probes == 1, "R6 probes", probes, 1);
    check(doneCnt == 1, "R6 done pulse", doneCnt, 1);
    check(toCnt == 0, "R6 no timeout", toCnt, 0);
    check(badByte == 0, "R2 address byte", badByte, 0);
    check(badHigh == 0, "R4 high time", badHigh, 0);
    check(stops == starts, "R10 stops", stops, starts);
    checkIdle("R1 idle after done");
  endtask

  task automatic testLateAck();
    clearStats(); nackFirst = 3; respondAddr = 7'h2B; expAddr = 7'h2B; slaveAddr = 7'h2B;
    pulseStart(); waitResult();
    check(probes == 4, "R7 probes", probes, 4);
    check(doneCnt == 1, "R5 done after ack", doneCnt, 1);
    check(badByte == 0, "R2 address byte", badByte, 0);
    check(badHigh == 0, "R3 R4 bit timing", badHigh, 0);
    check(minGap >= GAP, "R7 min gap", minGap, GAP);
    check(maxGap <= GAP + 2 * QTR + 4, "R7 max gap", maxGap, GAP + 2 * QTR + 4);
    check(stops == starts, "R10 stops", stops, starts);
  endtask

  task automatic testTimeout();
    clearStats(); nackFirst = 1000; respondAddr = 7'h7F; expAddr = 7'h7F; slaveAddr = 7'h7F;
    pulseStart(); waitResult();
    check(probes == MAXP, "R8 probe count", probes, MAXP);
    check(toCnt == 1, "R8 timeout pulse", toCnt, 1);
    check(doneCnt == 0, "R8 no done", doneCnt, 0);
    check(stops == starts, "R10 stops", stops, starts);
    checkIdle("R8 idle after timeout");
  endtask

  task automatic testWrongAddr();
    clearStats(); nackFirst = 0; respondAddr = 7'h51; expAddr = 7'h01; slaveAddr = 7'h01;
    pulseStart(); waitResult();
    check(toCnt == 1, "R5 unanswered address times out", toCnt, 1);
    check(badByte == 0, "R2 low address bits", badByte, 0);
  endtask

  task automatic testIgnoreMidRun();
    clearStats(); nackFirst = 2; respondAddr = 7'h3C; expAddr = 7'h3C; slaveAddr = 7'h3C;
    pulseStart();
    repeat (300) @(negedge clk);
    slaveAddr = 7'h11;
    pulseStart();
    waitResult();
    check(probes == 3, "R9 probes unchanged", probes, 3);
    check(badByte == 0, "R9 address held", badByte, 0);
    check(doneCnt == 1, "R9 single done", doneCnt, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    testReset();
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    testReset();
    testImmediateAck();
    testLateAck();
    testTimeout();
    testWrongAddr();
    testIgnoreMidRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule